// File: doc/BRIEF.md
# Multiply-Accumulate Coprocessor Unit

This unit is a register-mapped arithmetic helper that multiplies two 16-bit operands and combines the product with a 48-bit accumulator. A processor drives it through a plain single-port register bus. One write per cycle goes in, and reads are combinational. An 8-bit control word selects the operation, the signedness of the operands, how many operand writes start a computation and whether the single operand is squared. The same word holds the accumulator write permission, two self-clearing clear strobes and a sticky overflow flag.

Computation is started by the write of the last operand that the selected operand count requires. The 48-bit result, and the low word of the raw product, are registered on that same clock edge, so software can read them in the very next cycle. A new operation can be started in every cycle.

The register map is as follows. Address 0 is the control word. Address 1 is operand A and address 2 is operand B. Addresses 3, 4 and 5 hold accumulator bits [15:0], [31:16] and [47:32]. Address 6 holds the low product word. Address 7 reads zero.

Control word bits:
- [1:0] select the operation: 00 multiply, 01 accumulate, 10 subtract, 11 negate.
- [2] selects signed operands.
- [3] selects one-operand mode.
- [4] selects squaring.
- [5] enables accumulator writes.
- [6] is written as a clear-operands strobe and always reads 0.
- [7] is written as a clear-accumulator strobe and reads as the overflow flag.

Top module: `mac_unit`

## Requirements
- R1: After reset, every readable register (addresses 0 to 6) reads zero.
- R2: With control bit 3 clear, a write to operand B (address 2) starts an operation on the held A and the written B, and the result is readable in the next cycle. A write to A alone leaves the accumulator unchanged.
- R3: With control bit 3 set, a write to operand A (address 1) starts the operation. The second factor is the held B, or the written A itself when control bit 4 (square) is set. In two-operand mode, bit 4 has no effect.
- R4: With control bit 2 clear, the product is zero-extended. Code 00 loads the product, 01 adds it and 10 subtracts it. Code 11 behaves as code 00.
- R5: With control bit 2 set, the product is sign-extended. Code 00 loads it, 11 loads its negation, 01 adds it and 10 subtracts it.
- R6: The overflow flag is control bit 7 on read. It is set when an unsigned add carries out of bit 47, when an unsigned subtract borrows, or when a signed add or subtract leaves the 48-bit two's-complement range. Once set it stays set until the control register is written, and any control write clears it.
- R7: Writing control bit 6 as 1 zeroes both operand registers in the same cycle. Bit 6 always reads 0.
- R8: Writing control bit 7 as 1 zeroes the accumulator in the same cycle.
- R9: Writes to addresses 3 to 5 load the matching accumulator word only when control bit 5 is set. Otherwise they are ignored.
- R10: Address 6 returns the low 16 bits of the product of the most recent operation, before any negation. Operations started in consecutive cycles each take effect.
- R11: Address 7 reads zero, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for bus_addr |

## Verification
The accumulator, the low product word and the overflow flag are all visible one cycle after the write that changes them. A wrong trigger decision or a wrong extension therefore shows at the next read of addresses 3 to 6. A stale or missing overflow bit shows at the next control read. Because the overflow bit is sticky, one mishandled carry stays visible until the next control write. The bench compares every register after each operation, so an error is seen within one cycle of the write that caused it.

// File: rtl/mac_pkg.sv
package mac_pkg;

    typedef enum logic [1:0] {
        OP_MUL = 2'b00,
        OP_ADD = 2'b01,
        OP_SUB = 2'b10,
        OP_NEG = 2'b11
    } mac_op_e;

    // Control word layout, most significant field first
    typedef struct packed {
        logic    clr_acc_ovf;  // write: clear accumulator, read: overflow
        logic    clr_ops;      // write-only strobe
        logic    acc_wr_en;
        logic    square;
        logic    one_op;
        logic    is_signed;
        mac_op_e op;
    } ctrl_t;

    localparam int ADDR_CTRL = 0;
    localparam int ADDR_OPA  = 1;
    localparam int ADDR_OPB  = 2;
    localparam int ADDR_ACC  = 3;

endpackage

// File: rtl/mac_ctrl_reg.sv
module mac_ctrl_reg
    import mac_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    wr,
    input  ctrl_t   wdata,
    input  logic    ovf_set,
    output mac_op_e op,
    output logic    is_signed,
    output logic    one_op,
    output logic    square,
    output logic    acc_wr_en,
    output logic    ovf,
    output logic    clr_ops,
    output logic    clr_acc
);

    logic [5:0] cfg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr) begin
            cfg_q <= {wdata.acc_wr_en, wdata.square, wdata.one_op,
                      wdata.is_signed, wdata.op};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf <= 1'b0;
        end else if (wr) begin
            ovf <= 1'b0;
        end else if (ovf_set) begin
            ovf <= 1'b1;
        end
    end

    always_comb begin
        op        = mac_op_e'(cfg_q[1:0]);
        is_signed = cfg_q[2];
        one_op    = cfg_q[3];
        square    = cfg_q[4];
        acc_wr_en = cfg_q[5];
        clr_ops   = wr && wdata.clr_ops;
        clr_acc   = wr && wdata.clr_acc_ovf;
    end

    // R6: the flag holds until a control write
    p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !wr) |=> ovf);

    // R6: a control write clears the flag
    p_ovf_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> !ovf);

endmodule

// File: rtl/mac_arith.sv
module mac_arith
    import mac_pkg::*;
#(
    parameter int OPW  = 16,
    parameter int ACCW = 48
) (
    input  logic [OPW-1:0]  fac_x,
    input  logic [OPW-1:0]  fac_y,
    input  logic [ACCW-1:0] acc,
    input  mac_op_e         op,
    input  logic            is_signed,
    output logic [ACCW-1:0] acc_next,
    output logic [OPW-1:0]  prod_lo,
    output logic            ovf_hit
);

    localparam int PW  = 2 * OPW;
    localparam int EXT = ACCW - PW;

    logic        [PW-1:0]   prod_u;
    logic signed [PW-1:0]   prod_s;
    logic        [ACCW-1:0] pext;
    logic        [ACCW:0]   sum_add;
    logic        [ACCW:0]   sum_sub;
    mac_op_e                eff_op;

    always_comb begin
        prod_u  = fac_x * fac_y;
        prod_s  = $signed(fac_x) * $signed(fac_y);
        pext    = is_signed ? {{EXT{prod_s[PW-1]}}, prod_s}
                            : {{EXT{1'b0}}, prod_u};
        prod_lo = pext[OPW-1:0];
        sum_add = {1'b0, acc} + {1'b0, pext};
        sum_sub = {1'b0, acc} - {1'b0, pext};
        eff_op  = (!is_signed && op == OP_NEG) ? OP_MUL : op;
        acc_next = pext;
        ovf_hit  = 1'b0;
        unique case (eff_op)
            OP_MUL: begin
                acc_next = pext;
                ovf_hit  = 1'b0;
            end
            OP_ADD: begin
                acc_next = sum_add[ACCW-1:0];
                ovf_hit  = is_signed
                    ? ((acc[ACCW-1] == pext[ACCW-1]) &&
                       (sum_add[ACCW-1] != acc[ACCW-1]))
                    : sum_add[ACCW];
            end
            OP_SUB: begin
                acc_next = sum_sub[ACCW-1:0];
                ovf_hit  = is_signed
                    ? ((acc[ACCW-1] != pext[ACCW-1]) &&
                       (sum_sub[ACCW-1] != acc[ACCW-1]))
                    : sum_sub[ACCW];
            end
            OP_NEG: begin
                acc_next = '0 - pext;
                ovf_hit  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/mac_unit.sv
module mac_unit
    import mac_pkg::*;
#(
    parameter int OPW  = 16,
    parameter int ACCW = 48,
    parameter int AW   = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_wr,
    input  logic [AW-1:0]  bus_addr,
    input  logic [OPW-1:0] bus_wdata,
    output logic [OPW-1:0] bus_rdata
);

    localparam int NW        = ACCW / OPW;
    localparam int ADDR_PLO  = ADDR_ACC + NW;

    logic            wr_ctrl, wr_a, wr_b, fire;
    logic [NW-1:0]   wr_accw;
    mac_op_e         op;
    logic            is_signed, one_op, square, acc_wr_en, ovf;
    logic            clr_ops, clr_acc, ovf_hit;
    logic [OPW-1:0]  opa_q, opb_q, plo_q, fac_x, fac_y, prod_lo;
    logic [ACCW-1:0] acc_q, acc_next, acc_poke;

    assign wr_ctrl = bus_wr && (bus_addr == AW'(ADDR_CTRL));
    assign wr_a    = bus_wr && (bus_addr == AW'(ADDR_OPA));
    assign wr_b    = bus_wr && (bus_addr == AW'(ADDR_OPB));
    assign fire    = one_op ? wr_a : wr_b;

    for (genvar i = 0; i < NW; i++) begin : g_accw
        assign wr_accw[i] = bus_wr && (bus_addr == AW'(ADDR_ACC + i));
        assign acc_poke[i*OPW +: OPW] = (wr_accw[i] && acc_wr_en)
                                        ? bus_wdata : acc_q[i*OPW +: OPW];
    end

    always_comb begin
        if (one_op) begin
            fac_x = bus_wdata;
            fac_y = square ? bus_wdata : opb_q;
        end else begin
            fac_x = opa_q;
            fac_y = bus_wdata;
        end
    end

    mac_ctrl_reg u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (wr_ctrl),
        .wdata     (ctrl_t'(bus_wdata[7:0])),
        .ovf_set   (fire && ovf_hit),
        .op        (op),
        .is_signed (is_signed),
        .one_op    (one_op),
        .square    (square),
        .acc_wr_en (acc_wr_en),
        .ovf       (ovf),
        .clr_ops   (clr_ops),
        .clr_acc   (clr_acc)
    );

    mac_arith #(.OPW(OPW), .ACCW(ACCW)) u_arith (
        .fac_x     (fac_x),
        .fac_y     (fac_y),
        .acc       (acc_q),
        .op        (op),
        .is_signed (is_signed),
        .acc_next  (acc_next),
        .prod_lo   (prod_lo),
        .ovf_hit   (ovf_hit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opa_q <= '0;
            opb_q <= '0;
        end else if (clr_ops) begin
            opa_q <= '0;
            opb_q <= '0;
        end else begin
            if (wr_a) opa_q <= bus_wdata;
            if (wr_b) opb_q <= bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            plo_q <= '0;
        end else begin
            if (clr_acc)   acc_q <= '0;
            else if (fire) acc_q <= acc_next;
            else           acc_q <= acc_poke;
            if (fire)      plo_q <= prod_lo;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == AW'(ADDR_CTRL)) begin
            bus_rdata = OPW'({ovf, 1'b0, acc_wr_en, square, one_op,
                              is_signed, op});
        end else if (bus_addr == AW'(ADDR_OPA)) begin
            bus_rdata = opa_q;
        end else if (bus_addr == AW'(ADDR_OPB)) begin
            bus_rdata = opb_q;
        end else if (bus_addr == AW'(ADDR_PLO)) begin
            bus_rdata = plo_q;
        end
        for (int i = 0; i < NW; i++) begin
            if (bus_addr == AW'(ADDR_ACC + i)) bus_rdata = acc_q[i*OPW +: OPW];
        end
    end

    // R8: clear strobe empties the accumulator
    p_clr_acc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && bus_wdata[7]) |=> (acc_q == '0));

    // R7: clear strobe empties both operands
    p_clr_ops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && bus_wdata[6]) |=> (opa_q == '0 && opb_q == '0));

    // R2: no trigger, no strobe, no permitted word write -> accumulator holds
    p_acc_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr || bus_addr == AW'(ADDR_OPA) && !one_op) |=> $stable(acc_q));

    // R9: word writes without permission leave the accumulator alone
    p_accwr_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr >= AW'(ADDR_ACC) && bus_addr < AW'(ADDR_PLO)
         && !acc_wr_en) |=> $stable(acc_q));

    // R11: writes to the unused address change no state
    p_unused_addr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == AW'(ADDR_PLO + 1)) |=>
        ($stable(acc_q) && $stable(opa_q) && $stable(opb_q) && $stable(plo_q)));

endmodule

// File: tb/tb_mac_unit.sv
module tb_mac_unit;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;

    int n_run = 0;
    int n_fail = 0;

    // reference model state
    logic [5:0]  m_cfg = '0;
    logic [15:0] m_a = '0, m_b = '0, m_plo = '0;
    logic [47:0] m_acc = '0;
    logic        m_ovf = 1'b0;

    mac_unit dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [15:0] exp_read(input logic [2:0] a);
        case (a)
            3'd0: exp_read = {8'h00, m_ovf, 1'b0, m_cfg};
            3'd1: exp_read = m_a;
            3'd2: exp_read = m_b;
            3'd3: exp_read = m_acc[15:0];
            3'd4: exp_read = m_acc[31:16];
            3'd5: exp_read = m_acc[47:32];
            3'd6: exp_read = m_plo;
            default: exp_read = 16'h0000;
        endcase
    endfunction

    task automatic model_fire(input logic [15:0] x, input logic [15:0] y);
        longint p, sa, r;
        logic [48:0] s;
        logic [47:0] pe;
        if (m_cfg[2]) p = longint'($signed(x)) * longint'($signed(y));
        else          p = longint'(x) * longint'(y);
        pe = p[47:0];
        m_plo = p[15:0];
        sa = longint'($signed(m_acc));
        case (m_cfg[1:0])
            2'b00: m_acc = pe;
            2'b11: m_acc = m_cfg[2] ? 48'(-p) : pe;
            2'b01, 2'b10: begin
                if (m_cfg[2]) begin
                    r = (m_cfg[1:0] == 2'b01) ? sa + p : sa - p;
                    if (r > 64'sh7FFF_FFFF_FFFF || r < -64'sh8000_0000_0000)
                        m_ovf = 1'b1;
                    m_acc = r[47:0];
                end else begin
                    s = (m_cfg[1:0] == 2'b01) ? {1'b0, m_acc} + {1'b0, pe}
                                              : {1'b0, m_acc} - {1'b0, pe};
                    if (s[48]) m_ovf = 1'b1;
                    m_acc = s[47:0];
                end
            end
        endcase
    endtask

    task automatic model_write(input logic [2:0] a, input logic [15:0] d);
        case (a)
            3'd0: begin
                m_cfg = d[5:0];
                m_ovf = 1'b0;
                if (d[6]) begin m_a = '0; m_b = '0; end
                if (d[7]) m_acc = '0;
            end
            3'd1: begin
                m_a = d;
                if (m_cfg[3]) model_fire(d, m_cfg[4] ? d : m_b);
            end
            3'd2: begin
                m_b = d;
                if (!m_cfg[3]) model_fire(m_a, d);
            end
            3'd3: if (m_cfg[5]) m_acc[15:0]  = d;
            3'd4: if (m_cfg[5]) m_acc[31:16] = d;
            3'd5: if (m_cfg[5]) m_acc[47:32] = d;
            default: ;
        endcase
    endtask

    // one write per call; consecutive calls give writes in consecutive cycles
    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        model_write(a, d);
    endtask

    task automatic chk(input logic [2:0] a, input string tag);
        logic [15:0] e;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = a;
        #1;
        e = exp_read(a);
        n_run++;
        if (bus_rdata !== e) begin
            n_fail++;
            $display("FAIL %s addr=%0d actual=%h expected=%h", tag, a, bus_rdata, e);
        end
    endtask

    task automatic chk_all(input string tag);
        for (int i = 0; i < 8; i++) chk(3'(i), tag);
    endtask

    initial begin
        #(CLK_P * 150000);
        n_fail++;
        $display("FAIL R1 watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        chk_all("R1");
        // R11: unused address ignores writes and reads zero
        wr(3'd7, 16'hFFFF);
        chk_all("R11");

        // R2: two-operand unsigned multiply; A alone does nothing
        wr(3'd0, 16'h0000);
        wr(3'd1, 16'd300);
        chk(3'd3, "R2");
        wr(3'd2, 16'd700);
        chk_all("R2");

        // R4: unsigned code 11 acts as multiply, zero extension
        wr(3'd0, 16'h0003);
        wr(3'd1, 16'hFFFF);
        wr(3'd2, 16'hFFFF);
        chk_all("R4");

        // R5: signed negate, signed square in one-operand mode (R3)
        wr(3'd0, 16'h0007);
        wr(3'd1, 16'hFFFD);
        wr(3'd2, 16'h0005);
        chk_all("R5");
        wr(3'd0, 16'h001C);
        wr(3'd1, 16'hFFFD);
        chk_all("R3");
        // R3: one-operand without square uses held B
        wr(3'd0, 16'h0009);
        wr(3'd1, 16'h0011);
        chk_all("R3");
        // R3: square bit ignored in two-operand mode
        wr(3'd0, 16'h0010);
        wr(3'd2, 16'h0004);
        chk_all("R3");

        // R9: word writes ignored without permission, accepted with it
        wr(3'd0, 16'h0000);
        wr(3'd3, 16'hAAAA);
        chk_all("R9");
        wr(3'd0, 16'h0021);
        wr(3'd3, 16'hFFFF);
        wr(3'd4, 16'hFFFF);
        wr(3'd5, 16'hFFFF);
        chk_all("R9");

        // R6: unsigned carry, sticky through next op, cleared by control write
        wr(3'd1, 16'd1);
        wr(3'd2, 16'd1);
        chk(3'd0, "R6");
        wr(3'd2, 16'd0);
        chk_all("R6");
        wr(3'd0, 16'h0022);
        chk(3'd0, "R6");
        wr(3'd1, 16'd1);
        wr(3'd2, 16'd1);
        chk_all("R6");
        // R6: signed add past the top
        wr(3'd0, 16'h0025);
        wr(3'd5, 16'h7FFF);
        wr(3'd4, 16'hFFFF);
        wr(3'd3, 16'hFFFF);
        wr(3'd2, 16'd1);
        chk_all("R6");

        // R7, R8: clear strobes
        wr(3'd0, 16'h0040);
        chk_all("R7");
        wr(3'd1, 16'h1234);
        wr(3'd0, 16'h0080);
        chk_all("R8");

        // R10: back-to-back operations in consecutive cycles
        wr(3'd0, 16'h0005);
        wr(3'd1, 16'h8000);
        wr(3'd2, 16'h8000);
        wr(3'd2, 16'h7FFF);
        wr(3'd2, 16'h1235);
        chk_all("R10");

        // random mix, checked against the model
        for (int it = 0; it < 600; it++) begin
            int k;
            k = $urandom_range(0, 9);
            if (k == 0)
                wr(3'd0, 16'($urandom_range(0, 255)) & 16'h00FF &
                         (($urandom_range(0, 7) == 0) ? 16'h00FF : 16'h003F));
            else if (k == 1)
                wr(3'($urandom_range(3, 5)), 16'($urandom));
            else if (k < 6)
                wr(3'd2, 16'($urandom));
            else
                wr(3'd1, 16'($urandom));
            if (it % 3 == 0) chk_all("R10");
        end
        chk_all("R10");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule